// File: doc/BRIEF.md
# Successive Approximation ADC Controller

This block holds the digital side of an 8-bit successive-approximation converter. A processor reaches it through a small register bus with four byte-wide locations: a control register, a read-only result register, an interrupt configuration register and an interrupt request flag register. The block drives an 8-bit trial code to an external resistor-ladder DAC. It takes back a single comparator bit that reports whether the analog input lies above the trial voltage. It also drives a ladder-connect output and an input-channel select field toward the analog front end.

Software starts a conversion by writing 0 to the done bit of the control register. The controller clears the result, then tests the bits one at a time from the most significant down. It holds each trial code for a fixed number of clock cycles before it samples the comparator. When the last bit is resolved, the done bit rises. If interrupts are enabled, a sticky interrupt request rises in the same cycle. Only a software write lowers that request.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset all four registers read 0x00, `dac_code` is 0x00, and `irq`, `ladder_on` and `chan_sel` are 0.
- R2: A write to address 0 with bit 4 equal to 0 starts a conversion. On the next cycle the result register (address 1) reads 0x00 and the done bit (address 0, bit 4) reads 0.
- R3: A write to address 0 with bit 4 equal to 1 starts nothing. It leaves `dac_code`, the done bit and any running conversion undisturbed.
- R4: One cycle after the start, the trial code is 0x80. Each trial code is held for STEP_CYC cycles (default 6) before the comparator is sampled.
- R5: When `cmp_in` is 1 (input above trial voltage), the bit under test stays 1; when it is 0, the bit is cleared. The next lower bit is then set to 1 for the next trial.
- R6: Exactly 8 comparisons run, from bit 7 to bit 0. The done bit reads 1 exactly 1+8*STEP_CYC cycles (49 by default, within 50) after the start write edge. With an ideal ladder whose trial voltage for code n is (n-0.5) LSB, the result is min(floor(2*Vin/LSB / 2), 255).
- R7: With the enable bit (address 2, bit 7) at 1, completion sets the done bit and the request flag (address 3, bit 0, also the `irq` output) in the same cycle.
- R8: With the enable bit at 0, completion sets the done bit but leaves `irq` at 0.
- R9: Starting a new conversion does not clear `irq`. Writing 0 to address 3 bit 0 clears it.
- R10: `ladder_on` follows address 0 bit 3, and `chan_sel` follows address 0 bits 2:0, from the cycle after the write.
- R11: A start written during a conversion aborts it. The result reads 0x00 on the next cycle, and done arrives 49 cycles after the latest start.
- R12: During a conversion, the result register reads the current partial trial code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 1 | Comparator: 1 when input is above trial voltage |
| dac_code | output | 8 | Trial code to the resistor-ladder DAC |
| ladder_on | output | 1 | Connect reference to the ladder |
| chan_sel | output | 3 | Analog input channel select |
| irq | output | 1 | Sticky conversion interrupt request |

## Verification
A start write is captured on one clock edge. The cleared result and the low done bit are visible after that same edge. The 0x80 trial code appears after the next edge. Each trial decision lands 6 edges after the previous one, and done plus the request arrive 49 edges after the start. The bench counts edges with a free-running counter and samples every output at the falling edge. It compares the done edge against the start edge exactly, rather than waiting loosely. The trial-hold checks sample the code on the last held cycle and on the first changed one, so a pacing error of one cycle shows.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    localparam int CODE_W = 8;
    localparam int IDX_W  = $clog2(CODE_W);
    localparam int REG_W  = 8;
    localparam int CHAN_W = 3;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_RESULT = 2'd1;
    localparam logic [1:0] A_IRQCFG = 2'd2;
    localparam logic [1:0] A_IRQFLG = 2'd3;

    localparam int B_LADDER = 3;
    localparam int B_DONE   = 4;
    localparam int B_IRQEN  = 7;
    localparam int B_IRQFLG = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_TRIAL = 2'd2
    } sar_state_e;

    typedef struct packed {
        sar_state_e          st;
        logic [CODE_W-1:0]   code;
        logic [IDX_W-1:0]    idx;
    } sar_core_s;

    typedef struct packed {
        logic [CHAN_W-1:0]   chan;
        logic                ladder;
        logic                done;
        logic                irq_en;
        logic                irq_flag;
    } sar_regs_s;

endpackage

// File: rtl/sar_pacer.sv
module sar_pacer #(
    parameter int STEP_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && !clear_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clear_i || !run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o,
    output logic              trial_o,
    output logic              finish_o
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    sar_core_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        finish_o = 1'b0;
        if (start_i) begin
            s_d.st   = ST_CLEAR;
            s_d.code = '0;
            s_d.idx  = TOP_IDX;
        end else begin
            case (s_q.st)
                ST_CLEAR: begin
                    s_d.st            = ST_TRIAL;
                    s_d.idx           = TOP_IDX;
                    s_d.code          = '0;
                    s_d.code[TOP_IDX] = 1'b1;
                end
                ST_TRIAL: begin
                    if (tick_i) begin
                        if (!cmp_i) begin
                            s_d.code[s_q.idx] = 1'b0;
                        end
                        if (s_q.idx == '0) begin
                            s_d.st   = ST_IDLE;
                            finish_o = 1'b1;
                        end else begin
                            s_d.idx               = s_q.idx - 1'b1;
                            s_d.code[s_q.idx - 1'b1] = 1'b1;
                        end
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, code: '0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o  = s_q.code;
    assign busy_o  = (s_q.st != ST_IDLE);
    assign trial_o = (s_q.st == ST_TRIAL);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int STEP_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] dac_code,
    output logic              ladder_on,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              irq
);
    sar_regs_s regs_d, regs_q;

    logic wr_ctrl, wr_cfg, wr_flag, start_req;
    logic tick, conv_busy, conv_trial, conv_finish;
    logic unused_wbits;

    assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
    assign wr_cfg    = bus_we && (bus_addr == A_IRQCFG);
    assign wr_flag   = bus_we && (bus_addr == A_IRQFLG);
    assign start_req = wr_ctrl && !bus_wdata[B_DONE];
    assign unused_wbits = ^bus_wdata[6:5];

    sar_pacer #(.STEP_CYC(STEP_CYC)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_req),
        .run_i   (conv_trial),
        .tick_o  (tick)
    );

    sar_approx u_approx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_req),
        .tick_i   (tick),
        .cmp_i    (cmp_in),
        .code_o   (dac_code),
        .busy_o   (conv_busy),
        .trial_o  (conv_trial),
        .finish_o (conv_finish)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.chan   = bus_wdata[CHAN_W-1:0];
            regs_d.ladder = bus_wdata[B_LADDER];
            if (start_req) begin
                regs_d.done = 1'b0;
            end
        end
        if (wr_cfg) begin
            regs_d.irq_en = bus_wdata[B_IRQEN];
        end
        if (wr_flag) begin
            regs_d.irq_flag = bus_wdata[B_IRQFLG];
        end
        if (conv_finish) begin
            regs_d.done = 1'b1;
            if (regs_q.irq_en) begin
                regs_d.irq_flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CHAN_W-1:0] = regs_q.chan;
                bus_rdata[B_LADDER]   = regs_q.ladder;
                bus_rdata[B_DONE]     = regs_q.done;
            end
            A_RESULT: bus_rdata = dac_code;
            A_IRQCFG: bus_rdata[B_IRQEN]  = regs_q.irq_en;
            default:  bus_rdata[B_IRQFLG] = regs_q.irq_flag;
        endcase
    end

    assign ladder_on = regs_q.ladder;
    assign chan_sel  = regs_q.chan;
    assign irq       = regs_q.irq_flag;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
    import sar_adc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [CODE_W-1:0] dac_code,
    input logic              ladder_on,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              irq,
    input logic              done,
    input logic              irq_en,
    input logic              busy
);
    logic wr_start, wr_one, wr_clr, wr_ctl;
    logic unused_chk;

    assign wr_ctl   = bus_we && (bus_addr == A_CTRL);
    assign wr_start = wr_ctl && !bus_wdata[B_DONE];
    assign wr_one   = wr_ctl && bus_wdata[B_DONE];
    assign wr_clr   = bus_we && (bus_addr == A_IRQFLG) && !bus_wdata[B_IRQFLG];
    assign unused_chk = ^bus_wdata[7:5];

    // R2 / R11: a start clears the code and the done bit
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (dac_code == '0) && !done);

    // R4: the MSB trial follows the clear cycle
    p_msb_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start ##1 !wr_start) |=> (dac_code == 8'h80));

    // R3: writing 1 to the done bit while idle changes nothing
    p_ignore_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_one && !busy) |=> $stable(dac_code) && $stable(done));

    // R6: done stays low while a conversion is running
    p_busy_not_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R7: with interrupts enabled, completion raises the request with done
    p_done_irq_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && $past(irq_en)) |-> irq);

    // R8: with interrupts disabled, completion leaves the request low
    p_no_irq_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !$past(irq_en) && !$past(irq)
         && !$past(bus_we && (bus_addr == A_IRQFLG))) |-> !irq);

    // R9: the request only falls on a software clear
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_clr) |=> irq);

    // R10: ladder and channel outputs follow the control write
    p_ladder_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (ladder_on == $past(bus_wdata[B_LADDER]))
                && (chan_sel == $past(bus_wdata[CHAN_W-1:0])));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dac_code  (dac_code),
    .ladder_on (ladder_on),
    .chan_sel  (chan_sel),
    .irq       (irq),
    .done      (regs_q.done),
    .irq_en    (regs_q.irq_en),
    .busy      (conv_busy)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic       ladder_on;
    logic [2:0] chan_sel;
    logic       irq;
    logic [8:0] vin_x2 = 9'd0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit ended    = 0;

    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {9'd0,   8'd0},   {9'd1,   8'd0},   {9'd2,   8'd1},
        {9'd3,   8'd1},   {9'd255, 8'd127}, {9'd256, 8'd128},
        {9'd257, 8'd128}, {9'd300, 8'd150}, {9'd341, 8'd170},
        {9'd170, 8'd85},  {9'd510, 8'd255}, {9'd511, 8'd255}
    };

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ideal ladder: trial voltage for code n is (n - 0.5) LSB
    always_comb cmp_in = (int'(vin_x2) > 2 * int'(dac_code) - 1);

    sar_adc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .ladder_on(ladder_on), .chan_sel(chan_sel),
        .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done(output int at_cyc, output logic at_irq);
        logic [7:0] d;
        at_cyc = -1;
        at_irq = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rd(2'd0, d);
            if (d[4]) begin
                at_cyc = cyc;
                at_irq = irq;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int sc, dc;
        logic di;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reset register", int'(d), 0);
        end
        chk("R1 reset dac_code", int'(dac_code), 0);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset ladder_on", int'(ladder_on), 0);

        // R3 / R10: write 1 to done bit while idle, ladder on, channel 5
        bus_write(2'd0, 8'h1D);
        chk("R10 ladder_on", int'(ladder_on), 1);
        chk("R10 chan_sel", int'(chan_sel), 5);
        rd(2'd0, d);
        chk("R3 ctrl readback no start", int'(d), 8'h0D);
        chk("R3 dac_code unchanged", int'(dac_code), 0);

        // R7 setup: enable interrupt
        bus_write(2'd2, 8'h80);
        rd(2'd2, d);
        chk("R7 enable readback", int'(d), 8'h80);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vin_x2 = VEC[i][16:8];
            bus_write(2'd0, 8'h08);
            sc = cyc;
            rd(2'd1, d);
            chk("R2 result cleared", int'(d), 0);
            rd(2'd0, d);
            chk("R2 done low", int'(d[4]), 0);
            chk("R10 chan_sel after start", int'(chan_sel), 0);
            if (i > 0) chk("R9 irq kept on start", int'(irq), 1);
            @(negedge clk);
            chk("R4 msb trial", int'(dac_code), 8'h80);
            rd(2'd1, d);
            chk("R12 partial readback", int'(d), 8'h80);
            bus_write(2'd3, 8'h00);
            chk("R9 irq cleared by write", int'(irq), 0);
            wait_done(dc, di);
            chk("R6 done latency", dc - sc, 49);
            chk("R7 irq with done", int'(di), 1);
            rd(2'd1, d);
            chk("R6 result", int'(d), int'(VEC[i][7:0]));
        end

        // R4 / R5: step pacing and bit decisions, vin = 150 LSB
        vin_x2 = 9'd300;
        bus_write(2'd0, 8'h08);
        sc = cyc;
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            #1;
            if (k == 6)  chk("R4 trial held 6 cycles", int'(dac_code), 8'h80);
            if (k == 7)  chk("R5 bit kept, next set", int'(dac_code), 8'hC0);
            if (k == 12) chk("R4 second trial held", int'(dac_code), 8'hC0);
            if (k == 13) chk("R5 bit cleared, next set", int'(dac_code), 8'hA0);
        end
        // R3: writing 1 mid-conversion does not restart
        bus_write(2'd0, 8'h18);
        wait_done(dc, di);
        chk("R3 no restart latency", dc - sc, 49);
        rd(2'd1, d);
        chk("R5 final result", int'(d), 150);

        // R8: interrupt disabled
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h00);
        vin_x2 = 9'd100;
        bus_write(2'd0, 8'h08);
        wait_done(dc, di);
        chk("R8 done without irq", int'(di), 0);
        chk("R8 irq stays low", int'(irq), 0);
        rd(2'd1, d);
        chk("R8 result", int'(d), 50);

        // R11: abort and restart
        vin_x2 = 9'd400;
        bus_write(2'd0, 8'h08);
        repeat (20) @(negedge clk);
        vin_x2 = 9'd50;
        bus_write(2'd0, 8'h08);
        sc = cyc;
        chk("R11 restart clears code", int'(dac_code), 0);
        wait_done(dc, di);
        chk("R11 latency from restart", dc - sc, 49);
        rd(2'd1, d);
        chk("R11 restart result", int'(d), 25);

        finish_run();
    end
endmodule